// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This block is a watchdog with a small bank of 16-bit registers at even byte offsets. Once software turns it on, a down-counter counts a programmable interval in half-second steps, clocked by a slow `tick_i` strobe that pulses once every half second. The counter is refilled only when software writes a fixed pair of key words to the service register in the right order. A stray or misordered write gives no refill.

If the counter reaches zero, the block requests either an internal chip reset or an external reset output. A control bit picks which one. Some time before expiry, at a point that software programs, it can raise an interrupt whose status bit is cleared by writing one. Software can also request an internal reset pulse directly, or hold the external reset low.

A reset-cause flag records whether the latest warm reset followed an expiry. A power-down counter runs after boot and gives a one-cycle low pulse on the external reset output unless software disables it first. Two inputs, one for low-power mode and one for the wait state, can freeze the count when the matching control bits allow it.

Top module: `seq_wdog`

## Requirements
- R1: After power-on reset the registers read as follows. Control (offset 0x0) reads 0x0030. Cause (offset 0x4), interrupt control (offset 0x6) and outputs irq_o and sys_rst_o all read 0. The power-down register (offset 0x8) reads 0x0001, and ext_rst_n_o is 1.
- R2: The interval field sits in control bits 15:8. Writing a value N to it with the enable bit (control bit 2) set makes the counter expire on the (N+1)-th tick. When control bit 3 is clear, expiry drives sys_rst_o high, and it stays high until reset.
- R3: Writing 0x5555 to the service register (offset 0x2) and then 0xAAAA reloads the counter with the interval field plus one. Any other service write returns the sequence to its start without a reload.
- R4: Once the enable bit (control bit 2) is 1, writing 0 to it leaves it at 1 until reset.
- R5: Changing the interval field while the timer runs does not alter the count in progress. The new value is used at the next reload.
- R6: When control bit 3 is set, expiry drives ext_rst_n_o low and leaves sys_rst_o low.
- R7: Writing control bit 4 as 0 produces a one-cycle high pulse on sys_rst_o, and bit 4 reads back as 1. While control bit 5 holds 0, ext_rst_n_o is low.
- R8: The pre-timeout status (interrupt register bit 14) sets when a tick brings the counter to the value in bits 7:0. irq_o equals that status ANDed with the interrupt enable (bit 15). Writing 1 to bit 14 clears the status, and writing 0 to it has no effect.
- R9: Cause register bit 1 reads 1 after a warm reset (rst_i) that arrived while an expiry was pending, and 0 after a warm reset without one.
- R10: Control bits 0 and 7 take their value from the first control write after reset. Later writes leave them unchanged.
- R11: While lp_i is high and control bit 0 is set, or wait_i is high and control bit 7 is set, ticks do not decrement the counter. Counting resumes when the condition ends.
- R12: After reset, the power-down counter pulses ext_rst_n_o low for exactly one clock on the PD_TICKS-th tick. Writing 0 to bit 0 of the power-down register first prevents the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, synchronous active high, clears everything |
| rst_i | input | 1 | Warm reset, synchronous active high, keeps the cause flag |
| tick_i | input | 1 | One-cycle strobe per half second |
| lp_i | input | 1 | Low-power mode indication |
| wait_i | input | 1 | Wait-state indication |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte offset for read and write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Pre-timeout interrupt |
| sys_rst_o | output | 1 | Internal reset request |
| ext_rst_n_o | output | 1 | External reset output, active low |

## Verification
The reset-cause flag is the hardest state to reach from the ports. It only becomes visible after the block has expired and a warm reset has then wiped every other register. The bench lets the counter run out, pulses rst_i while the expiry is still pending, reads the cause register, and then resets again to see the flag fall. The power-down pulse also fires on its own after any reset, so each scenario first disables it through the register port; only the scenario dedicated to it leaves it running.

// File: rtl/seq_wdog_pkg.sv
package seq_wdog_pkg;

    localparam int REG_W = 16;
    localparam int TMO_W = 8;
    localparam int PRE_W = 8;
    localparam int CNT_W = TMO_W + 1;
    localparam int ADR_W = 4;

    localparam logic [ADR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADR_W-1:0] OFS_SVC  = 4'h2;
    localparam logic [ADR_W-1:0] OFS_CAUS = 4'h4;
    localparam logic [ADR_W-1:0] OFS_ICTL = 4'h6;
    localparam logic [ADR_W-1:0] OFS_PDWN = 4'h8;

    localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             wait_hold;
        logic             ext_n;
        logic             act_ext;
        logic             en;
        logic             lp_hold;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{tmo: '0, wait_hold: 1'b0, ext_n: 1'b1,
                                   act_ext: 1'b0, en: 1'b0, lp_hold: 1'b0};

    // control read image: bit 4 always reads idle (1), bits 6 and 1 read 0
    function automatic logic [REG_W-1:0] ctrl_image(input ctrl_t c);
        return {c.tmo, c.wait_hold, 1'b0, c.ext_n, 1'b1, c.act_ext, c.en, 1'b0, c.lp_hold};
    endfunction

    function automatic logic [CNT_W-1:0] tmo_to_count(input logic [TMO_W-1:0] t);
        return CNT_W'(t) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/seq_wdog_regs.sv
module seq_wdog_regs
    import seq_wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  logic [ADR_W-1:0] addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             pre_hit_i,
    input  logic             expired_i,
    output logic [REG_W-1:0] rdata_o,
    output ctrl_t            ctrl_o,
    output logic             ie_o,
    output logic             wtis_o,
    output logic [PRE_W-1:0] pre_o,
    output logic             armed_o,
    output logic             start_o,
    output logic             reload_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             swr_o,
    output logic             pd_en_o
);

    ctrl_t            ctrl_q;
    logic             locked_q;
    logic             armed_q;
    logic             ie_q;
    logic             wtis_q;
    logic [PRE_W-1:0] pre_q;
    logic             swr_q;
    logic             pd_en_q;
    logic             cause_q;

    logic wr_ctrl, wr_svc, wr_ictl, wr_pdwn;
    logic rst_any;

    assign rst_any = por_i | rst_i;
    assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
    assign wr_svc  = wr_i && (addr_i == OFS_SVC);
    assign wr_ictl = wr_i && (addr_i == OFS_ICTL);
    assign wr_pdwn = wr_i && (addr_i == OFS_PDWN);

    assign start_o    = wr_ctrl && wdata_i[2] && !ctrl_q.en;
    assign reload_o   = wr_svc && (wdata_i == KEY_FIRE) && armed_q;
    assign load_val_o = tmo_to_count(wr_ctrl ? wdata_i[15:8] : ctrl_q.tmo);

    always_ff @(posedge clk_i) begin
        if (rst_any) begin
            ctrl_q   <= CTRL_RST;
            locked_q <= 1'b0;
            armed_q  <= 1'b0;
            ie_q     <= 1'b0;
            wtis_q   <= 1'b0;
            pre_q    <= '0;
            swr_q    <= 1'b0;
            pd_en_q  <= 1'b1;
        end else begin
            swr_q <= wr_ctrl && !wdata_i[4];
            if (wr_ctrl) begin
                ctrl_q.tmo     <= wdata_i[15:8];
                ctrl_q.ext_n   <= wdata_i[5];
                ctrl_q.act_ext <= wdata_i[3];
                ctrl_q.en      <= ctrl_q.en | wdata_i[2];
                if (!locked_q) begin
                    ctrl_q.lp_hold   <= wdata_i[0];
                    ctrl_q.wait_hold <= wdata_i[7];
                end
                locked_q <= 1'b1;
            end
            if (wr_svc) begin
                armed_q <= (wdata_i == KEY_ARM);
            end
            if (wr_ictl) begin
                ie_q  <= wdata_i[15];
                pre_q <= wdata_i[PRE_W-1:0];
            end
            if (pre_hit_i) begin
                wtis_q <= 1'b1;
            end else if (wr_ictl && wdata_i[14]) begin
                wtis_q <= 1'b0;
            end
            if (wr_pdwn) begin
                pd_en_q <= pd_en_q & wdata_i[0];
            end
        end
    end

    // cause flag survives the warm reset and samples the pending expiry
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            cause_q <= 1'b0;
        end else if (rst_i) begin
            cause_q <= expired_i;
        end
    end

    always_comb begin
        case (addr_i)
            OFS_CTRL: rdata_o = ctrl_image(ctrl_q);
            OFS_CAUS: rdata_o = {14'b0, cause_q, 1'b0};
            OFS_ICTL: rdata_o = {ie_q, wtis_q, {(REG_W-PRE_W-2){1'b0}}, pre_q};
            OFS_PDWN: rdata_o = {15'b0, pd_en_q};
            default:  rdata_o = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign ie_o    = ie_q;
    assign wtis_o  = wtis_q;
    assign pre_o   = pre_q;
    assign armed_o = armed_q;
    assign swr_o   = swr_q;
    assign pd_en_o = pd_en_q;

endmodule

// File: rtl/seq_wdog_count.sv
module seq_wdog_count
    import seq_wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             hold_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o,
    output logic             pre_hit_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             expired_q;
    logic             step;
    logic [CNT_W-1:0] nxt;

    assign step      = tick_i && en_i && !hold_i && !expired_q && (cnt_q != '0);
    assign nxt       = cnt_q - CNT_W'(1);
    assign pre_hit_o = step && !load_i && (nxt == {1'b0, pre_i});

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (step) begin
            cnt_q <= nxt;
            if (nxt == '0) begin
                expired_q <= 1'b1;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign expired_o = expired_q;

endmodule

// File: rtl/seq_wdog_pdc.sv
module seq_wdog_pdc #(
    parameter int PD_TICKS = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic en_i,
    output logic pulse_o
);

    localparam int PD_W = $clog2(PD_TICKS + 1);

    logic [PD_W-1:0] cnt_q;
    logic            done_q;
    logic            pulse_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            done_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick_i && en_i && !done_q) begin
                if (cnt_q == PD_W'(PD_TICKS - 1)) begin
                    pulse_q <= 1'b1;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + PD_W'(1);
                end
            end
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/seq_wdog.sv
module seq_wdog
    import seq_wdog_pkg::*;
#(
    parameter int PD_TICKS = 64
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             lp_i,
    input  logic             wait_i,
    input  logic             bus_wr_i,
    input  logic [ADR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    output logic             irq_o,
    output logic             sys_rst_o,
    output logic             ext_rst_n_o
);

    ctrl_t            ctrl;
    logic             rst_any;
    logic             ie, wtis, armed, start, reload, load, swr, pd_en, pd_pulse;
    logic             hold, expired, pre_hit;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] load_val, cnt;

    assign rst_any = por_i | rst_i;
    assign load    = start | reload;
    assign hold    = (lp_i & ctrl.lp_hold) | (wait_i & ctrl.wait_hold);

    seq_wdog_regs u_regs (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .rst_i      (rst_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .pre_hit_i  (pre_hit),
        .expired_i  (expired),
        .rdata_o    (bus_rdata_o),
        .ctrl_o     (ctrl),
        .ie_o       (ie),
        .wtis_o     (wtis),
        .pre_o      (pre),
        .armed_o    (armed),
        .start_o    (start),
        .reload_o   (reload),
        .load_val_o (load_val),
        .swr_o      (swr),
        .pd_en_o    (pd_en)
    );

    seq_wdog_count u_count (
        .clk_i      (clk_i),
        .rst_i      (rst_any),
        .tick_i     (tick_i),
        .en_i       (ctrl.en),
        .hold_i     (hold),
        .load_i     (load),
        .load_val_i (load_val),
        .pre_i      (pre),
        .cnt_o      (cnt),
        .expired_o  (expired),
        .pre_hit_o  (pre_hit)
    );

    seq_wdog_pdc #(.PD_TICKS(PD_TICKS)) u_pdc (
        .clk_i   (clk_i),
        .rst_i   (rst_any),
        .tick_i  (tick_i),
        .en_i    (pd_en),
        .pulse_o (pd_pulse)
    );

    assign irq_o       = wtis & ie;
    assign sys_rst_o   = (expired & ~ctrl.act_ext) | swr;
    assign ext_rst_n_o = ~((expired & ctrl.act_ext) | ~ctrl.ext_n | pd_pulse);

endmodule

// File: rtl/seq_wdog_chk.sv
module seq_wdog_chk
    import seq_wdog_pkg::*;
(
    input logic             clk_i,
    input logic             rst_any,
    input logic             en,
    input logic             expired,
    input logic             swr,
    input logic             pd_pulse,
    input logic             load,
    input logic             hold,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             ie
);

    // R4
    en_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        en |=> en);

    // R2
    expiry_held_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        expired |=> expired);

    // R7
    swr_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        swr |=> !swr);

    // R12
    pd_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        pd_pulse |=> !pd_pulse);

    // R3
    no_rise_without_load_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        !load |=> (cnt <= $past(cnt)));

    // R11
    hold_freezes_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        (hold && !load) |=> $stable(cnt));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_any)
        irq |-> ie);

endmodule

bind seq_wdog seq_wdog_chk u_chk (
    .clk_i    (clk_i),
    .rst_any  (rst_any),
    .en       (ctrl.en),
    .expired  (expired),
    .swr      (swr),
    .pd_pulse (pd_pulse),
    .load     (load),
    .hold     (hold),
    .cnt      (cnt),
    .irq      (irq_o),
    .ie       (ie)
);

// File: tb/seq_wdog_bench.sv
module seq_wdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BENCH_PD   = 4;

    logic        clk_i = 1'b0;
    logic        por_i = 1'b1;
    logic        rst_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        lp_i = 1'b0;
    logic        wait_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [3:0]  bus_addr_i = 4'h0;
    logic [15:0] bus_wdata_i = 16'h0;
    logic [15:0] bus_rdata_o;
    logic        irq_o, sys_rst_o, ext_rst_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    seq_wdog #(.PD_TICKS(BENCH_PD)) u_seq_wdog (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .lp_i        (lp_i),
        .wait_i      (wait_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .sys_rst_o   (sys_rst_o),
        .ext_rst_n_o (ext_rst_n_o)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk_i);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk_i);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic tick();
        @(negedge clk_i);
        tick_i = 1'b1;
        @(negedge clk_i);
        tick_i = 1'b0;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic warm_reset();
        @(negedge clk_i);
        rst_i = 1'b1;
        @(negedge clk_i);
        rst_i = 1'b0;
        #1;
    endtask

    task automatic fresh();
        warm_reset();
        wr(4'h8, 16'h0000);
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        rd(4'h0, d); chk("R1 ctrl", d, 16'h0030);
        rd(4'h4, d); chk("R1 cause", d, 16'h0000);
        rd(4'h6, d); chk("R1 ictl", d, 16'h0000);
        rd(4'h8, d); chk("R1 pdwn", d, 16'h0001);
        chk("R1 outs", {13'b0, irq_o, sys_rst_o, ext_rst_n_o}, 16'h0001);
    endtask

    task automatic t_powerdown();
        int lows;
        logic [15:0] d;
        lows = 0;
        for (int i = 0; i < BENCH_PD + 2; i++) begin
            tick();
            if (!ext_rst_n_o) lows++;
            @(negedge clk_i); #1;
            if (!ext_rst_n_o) lows++;
        end
        chk("R12 pulse count", 16'(lows), 16'd1);
        fresh();
        lows = 0;
        for (int i = 0; i < BENCH_PD + 2; i++) begin
            tick();
            if (!ext_rst_n_o) lows++;
        end
        chk("R12 disabled", 16'(lows), 16'd0);
        rd(4'h8, d); chk("R12 pdwn reads 0", d, 16'h0000);
    endtask

    task automatic t_expire_and_cause();
        logic [15:0] d;
        fresh();
        wr(4'h0, 16'h0334);
        tick();
        wr(4'h0, 16'h0330);
        rd(4'h0, d); chk("R4 enable sticky", d, 16'h0334);
        ticks(2);
        chk("R2 before expiry", {15'b0, sys_rst_o}, 16'd0);
        tick();
        chk("R2 expiry at N+1", {15'b0, sys_rst_o}, 16'd1);
        repeat (3) @(negedge clk_i);
        #1;
        chk("R2 held", {15'b0, sys_rst_o}, 16'd1);
        warm_reset();
        rd(4'h4, d); chk("R9 cause set", d, 16'h0002);
        chk("R9 sys_rst cleared", {15'b0, sys_rst_o}, 16'd0);
        warm_reset();
        rd(4'h4, d); chk("R9 cause clear", d, 16'h0000);
    endtask

    task automatic t_service();
        fresh();
        wr(4'h0, 16'h0334);
        ticks(3);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        ticks(3);
        chk("R3 reload kept alive", {15'b0, sys_rst_o}, 16'd0);
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        tick();
        chk("R3 bad sequence no reload", {15'b0, sys_rst_o}, 16'd1);
    endtask

    task automatic t_field_change();
        fresh();
        wr(4'h0, 16'h0134);
        wr(4'h0, 16'h0534);
        ticks(2);
        chk("R5 old interval used", {15'b0, sys_rst_o}, 16'd1);
        fresh();
        wr(4'h0, 16'h0134);
        wr(4'h0, 16'h0534);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        ticks(5);
        chk("R5 new interval not yet", {15'b0, sys_rst_o}, 16'd0);
        tick();
        chk("R5 new interval expiry", {15'b0, sys_rst_o}, 16'd1);
    endtask

    task automatic t_ext_action();
        fresh();
        wr(4'h0, 16'h013C);
        tick();
        chk("R6 before", {14'b0, sys_rst_o, ext_rst_n_o}, 16'b01);
        tick();
        chk("R6 external only", {14'b0, sys_rst_o, ext_rst_n_o}, 16'b00);
    endtask

    task automatic t_soft_reset();
        logic [15:0] d;
        fresh();
        wr(4'h0, 16'h0020);
        chk("R7 pulse high", {15'b0, sys_rst_o}, 16'd1);
        @(negedge clk_i); #1;
        chk("R7 pulse one cycle", {15'b0, sys_rst_o}, 16'd0);
        rd(4'h0, d); chk("R7 bit4 reads 1", d, 16'h0030);
        wr(4'h0, 16'h0010);
        chk("R7 ext held low", {15'b0, ext_rst_n_o}, 16'd0);
        rd(4'h0, d); chk("R7 bit5 reads 0", d, 16'h0010);
        wr(4'h0, 16'h0030);
        chk("R7 ext released", {15'b0, ext_rst_n_o}, 16'd1);
    endtask

    task automatic t_pretimeout();
        logic [15:0] d;
        fresh();
        wr(4'h6, 16'h8002);
        wr(4'h0, 16'h0534);
        ticks(3);
        chk("R8 not yet", {15'b0, irq_o}, 16'd0);
        tick();
        chk("R8 fires", {15'b0, irq_o}, 16'd1);
        rd(4'h6, d); chk("R8 status", d, 16'hC002);
        wr(4'h6, 16'h8002);
        chk("R8 write 0 keeps", {15'b0, irq_o}, 16'd1);
        wr(4'h6, 16'hC002);
        chk("R8 w1c", {15'b0, irq_o}, 16'd0);
        rd(4'h6, d); chk("R8 status cleared", d, 16'h8002);
        tick();
        chk("R8 no refire", {15'b0, irq_o}, 16'd0);
    endtask

    task automatic t_write_once();
        logic [15:0] d;
        fresh();
        wr(4'h0, 16'h0031);
        wr(4'h0, 16'h00B0);
        rd(4'h0, d); chk("R10 bits locked", d, 16'h0031);
    endtask

    task automatic t_suspend();
        fresh();
        wr(4'h0, 16'h0135);
        lp_i = 1'b1;
        ticks(5);
        chk("R11 held in low power", {15'b0, sys_rst_o}, 16'd0);
        lp_i = 1'b0;
        tick();
        chk("R11 resumed one", {15'b0, sys_rst_o}, 16'd0);
        tick();
        chk("R11 resumed expiry", {15'b0, sys_rst_o}, 16'd1);
        fresh();
        wr(4'h0, 16'h0134);
        wait_i = 1'b1;
        ticks(2);
        chk("R11 wait ignored when bit clear", {15'b0, sys_rst_o}, 16'd1);
        fresh();
        wr(4'h0, 16'h01B4);
        ticks(3);
        chk("R11 wait hold", {15'b0, sys_rst_o}, 16'd0);
        wait_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        por_i = 1'b0;
        #1;
        t_reset_state();
        t_powerdown();
        t_expire_and_cause();
        t_service();
        t_field_change();
        t_ext_action();
        t_soft_reset();
        t_pretimeout();
        t_write_once();
        t_suspend();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before the tests finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule